// File: doc/BRIEF.md
# Zoned Variable-Page TLB Lookup

This block searches every slot of a fully associative translation buffer in parallel for a virtual address. Each slot holds a page of its own size, from 1 KB to 16 MB. A slot is either private to one process through an 8-bit owner tag or shared by all processes. A 32-bit zone register holds sixteen 2-bit codes. The code picked by a slot can block user access to that slot, or can widen its write and execute rights.

Per request, the block reports one of three outcomes: hit, miss, or protection fault. On a hit it also returns the slot index, the page-size code and the translated physical address. The search itself is combinational; the outcome is captured in a result register one cycle after the request. That register is a small state machine with four states:

- `RES_IDLE`: no request in the previous cycle.
- `RES_HIT`: the request was translated.
- `RES_MISS`: no slot matched.
- `RES_PROT`: a slot matched but refused the access.

Every cycle, the register takes a transition chosen from the current request: *no request* → `RES_IDLE`, *no match* → `RES_MISS`, *permitted* → `RES_HIT`, *refused* → `RES_PROT`.

Slots are loaded through a separate write port.
- A slot's tag word holds:
  - the page number in bits 31:10,
  - the size code in bits 9:7,
  - the valid flag in bit 6.
- Its data word holds:
  - the physical page in bits 31:10,
  - execute permission in bit 9,
  - write permission in bit 8,
  - the zone select in bits 7:4.
- The owner tag is written alongside.

Top module: `zoned_tlb_lookup`

## Requirements
- R1: Size code c (0..7) gives a page of 1024·4^c bytes. An address matches a slot when all address bits at and above bit 10+2c equal the slot's page number. On a hit the physical address is the slot's physical page above that bit, with the virtual address bits below it.
- R2: A slot whose valid flag (tag bit 6) is 0 never matches.
- R3: An owner tag of 0 matches any process. A nonzero owner tag matches only when it equals `cur_pid`.
- R4: Zone code 0 makes a slot not match for user accesses (`lk_user`=1), so the search continues with later slots. For supervisor accesses, zone code 0 uses the slot's own rights.
- R5: The zone code for select z is `zone_reg` bits [31-2z:30-2z]. Code 1 uses the slot's own write (data bit 8) and execute (data bit 9) rights. Code 2 grants both rights in supervisor mode only. Code 3 grants both rights in every mode.
- R6: A zone select greater than ZONE_COUNT behaves as zone code 1, whatever the zone register holds.
- R7: The access kind is encoded as 0 = read, 1 = write, 2 = fetch. Reads are always permitted. A write without write right, or a fetch without execute right, gives a protection fault on the first matching slot; the search does not continue to later slots.
- R8: When no slot matches, the outcome is a miss.
- R9: When several slots match, the lowest-indexed one decides the outcome and the reported index.
- R10: The outcome appears one clock after `lk_valid`, with exactly one of hit, miss or fault raised. With no request, all three are low. After reset all outputs are zero. On a hit or fault, `res_idx` and `res_size` describe the deciding slot.
- R11: A slot written on one clock edge is used by any lookup that starts after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load a slot |
| wr_idx | input | IDX_W | Slot to load |
| wr_tag | input | 32 | Page number, size code, valid flag |
| wr_data | input | 32 | Physical page, execute, write, zone select |
| wr_tid | input | 8 | Owner tag, 0 = shared |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_kind | input | 2 | 0 read, 1 write, 2 fetch |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| cur_pid | input | 8 | Current process ID |
| zone_reg | input | 32 | Sixteen 2-bit zone codes |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | No slot matched |
| res_prot | output | 1 | Protection fault |
| res_idx | output | IDX_W | Deciding slot |
| res_paddr | output | 32 | Translated address (hit only, else 0) |
| res_size | output | 3 | Size code of deciding slot |

## Verification
Every lookup result is due exactly one clock after the edge that samples `lk_valid`. The bench drives a request on a falling edge and reads hit, miss, fault, index, size and address on the next falling edge, half a period after the result register loads. A slot load takes effect at the rising edge after `wr_en`, so each lookup is issued at least one falling edge after its last slot write. Expected outcomes come from an arithmetic model of the page mask, owner tag and zone codes, swept over all size codes, all zone codes, both modes, all access kinds and all right combinations.

// File: rtl/ztlb_pkg.sv
package ztlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_t;

    typedef enum logic [1:0] {
        RES_IDLE,
        RES_HIT,
        RES_MISS,
        RES_PROT
    } res_state_t;

    localparam int PAGE_W = 22;   // address bits 31:10

    typedef struct packed {
        logic              valid;
        logic [PAGE_W-1:0] vpage;
        logic [2:0]        size;
        logic [7:0]        owner;
        logic [PAGE_W-1:0] ppage;
        logic              may_exec;
        logic              may_write;
        logic [3:0]        zsel;
    } slot_t;

    // Mask over address bits 31:10 keeping only those above the page offset.
    function automatic logic [PAGE_W-1:0] page_keep(input logic [2:0] code);
        logic [PAGE_W-1:0] low;
        low = (PAGE_W'(1) << ({2'b0, code} << 1)) - PAGE_W'(1);
        return ~low;
    endfunction

endpackage

// File: rtl/ztlb_slot_store.sv
module ztlb_slot_store
    import ztlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  slot_t                    wr_slot,
    output slot_t [ENTRIES-1:0]      slots_q
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots_q[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                slots_q[i] <= wr_slot;
            end
        end
    end

endmodule

// File: rtl/ztlb_match_cell.sv
module ztlb_match_cell
    import ztlb_pkg::*;
#(
    parameter int ZONE_COUNT = 15,
    parameter bit ZONES_ON   = 1'b1
) (
    input  slot_t        slot,
    input  logic [31:0]  vaddr,
    input  logic [1:0]   kind,
    input  logic         user,
    input  logic [7:0]   pid,
    input  logic [31:0]  zone_reg,
    output logic         claims,
    output logic         allowed,
    output logic [31:0]  paddr
);

    logic [PAGE_W-1:0] keep;
    logic              page_eq;
    logic              owner_ok;
    logic [31:0]       zone_shift;
    logic [1:0]        zcode;
    logic              zone_block;
    logic              wr_ok;
    logic              ex_ok;

    always_comb begin
        keep       = page_keep(slot.size);
        page_eq    = ((vaddr[31:10] ^ slot.vpage) & keep) == '0;
        owner_ok   = (slot.owner == 8'd0) || (slot.owner == pid);
        zone_shift = zone_reg >> (5'd30 - {slot.zsel, 1'b0});
        if (!ZONES_ON || int'(slot.zsel) > ZONE_COUNT) begin
            zcode = 2'd1;
        end else begin
            zcode = zone_shift[1:0];
        end
        zone_block = (zcode == 2'd0) && user;
        wr_ok      = slot.may_write || (zcode == 2'd3) || (zcode == 2'd2 && !user);
        ex_ok      = slot.may_exec  || (zcode == 2'd3) || (zcode == 2'd2 && !user);
        claims     = slot.valid && page_eq && owner_ok && !zone_block;
        unique case (kind)
            ACC_WRITE: allowed = wr_ok;
            ACC_FETCH: allowed = ex_ok;
            default:   allowed = 1'b1;
        endcase
        paddr = {(slot.ppage & keep) | (vaddr[31:10] & ~keep), vaddr[9:0]};
    end

endmodule

// File: rtl/ztlb_first_pick.sv
module ztlb_first_pick #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] claims,
    output logic               any,
    output logic [IDX_W-1:0]   first
);

    always_comb begin
        any   = |claims;
        first = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (claims[i]) begin
                first = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/zoned_tlb_lookup.sv
module zoned_tlb_lookup
    import ztlb_pkg::*;
#(
    parameter int ENTRIES    = 64,
    parameter int ZONE_COUNT = 15,
    parameter bit ZONES_ON   = 1'b1,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_tag,
    input  logic [31:0]      wr_data,
    input  logic [7:0]       wr_tid,
    input  logic             lk_valid,
    input  logic [31:0]      lk_vaddr,
    input  logic [1:0]       lk_kind,
    input  logic             lk_user,
    input  logic [7:0]       cur_pid,
    input  logic [31:0]      zone_reg,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_prot,
    output logic [IDX_W-1:0] res_idx,
    output logic [31:0]      res_paddr,
    output logic [2:0]       res_size
);

    slot_t                    wr_slot;
    slot_t [ENTRIES-1:0]      slots;
    logic  [ENTRIES-1:0]      claims;
    logic  [ENTRIES-1:0]      allowed;
    logic  [ENTRIES-1:0][31:0] paddrs;
    logic                     any;
    logic  [IDX_W-1:0]        first;
    logic                     unused_fields;

    res_state_t               state_q, state_d;
    logic [IDX_W-1:0]         idx_q;
    logic [31:0]              paddr_q;
    logic [2:0]               size_q;

    assign unused_fields = ^{wr_tag[5:0], wr_data[3:0]};

    always_comb begin
        wr_slot.valid     = wr_tag[6];
        wr_slot.vpage     = wr_tag[31:10];
        wr_slot.size      = wr_tag[9:7];
        wr_slot.owner     = wr_tid;
        wr_slot.ppage     = wr_data[31:10];
        wr_slot.may_exec  = wr_data[9];
        wr_slot.may_write = wr_data[8];
        wr_slot.zsel      = wr_data[7:4];
    end

    ztlb_slot_store #(.ENTRIES(ENTRIES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_slot (wr_slot),
        .slots_q (slots)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
        ztlb_match_cell #(.ZONE_COUNT(ZONE_COUNT), .ZONES_ON(ZONES_ON)) u_cell (
            .slot     (slots[i]),
            .vaddr    (lk_vaddr),
            .kind     (lk_kind),
            .user     (lk_user),
            .pid      (cur_pid),
            .zone_reg (zone_reg),
            .claims   (claims[i]),
            .allowed  (allowed[i]),
            .paddr    (paddrs[i])
        );
    end

    ztlb_first_pick #(.ENTRIES(ENTRIES)) u_pick (
        .claims (claims),
        .any    (any),
        .first  (first)
    );

    // Next-state selection: the outcome of this cycle's request.
    always_comb begin
        if (!lk_valid) begin
            state_d = RES_IDLE;
        end else if (!any) begin
            state_d = RES_MISS;
        end else if (allowed[first]) begin
            state_d = RES_HIT;
        end else begin
            state_d = RES_PROT;
        end
    end

    // State register plus the data captured with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
            idx_q   <= '0;
            paddr_q <= '0;
            size_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= (state_d == RES_HIT || state_d == RES_PROT) ? first : '0;
            paddr_q <= (state_d == RES_HIT) ? paddrs[first] : '0;
            size_q  <= (state_d == RES_HIT || state_d == RES_PROT) ? slots[first].size : 3'd0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        res_hit  = 1'b0;
        res_miss = 1'b0;
        res_prot = 1'b0;
        unique case (state_q)
            RES_HIT:  res_hit  = 1'b1;
            RES_MISS: res_miss = 1'b1;
            RES_PROT: res_prot = 1'b1;
            default:  ;
        endcase
        res_idx   = idx_q;
        res_paddr = paddr_q;
        res_size  = size_q;
    end

endmodule

// File: rtl/ztlb_checker.sv
module ztlb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [1:0]  lk_kind,
    input logic [31:0] lk_vaddr,
    input logic        res_hit,
    input logic        res_miss,
    input logic        res_prot,
    input logic [31:0] res_paddr
);

    assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_hit, res_miss, res_prot}));

    assert_outcome_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_hit || res_miss || res_prot));

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(res_hit || res_miss || res_prot));

    assert_read_never_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == 2'd0) |=> !res_prot);

    assert_offset_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!res_hit || res_paddr[9:0] == $past(lk_vaddr[9:0])));

endmodule

bind zoned_tlb_lookup ztlb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_kind   (lk_kind),
    .lk_vaddr  (lk_vaddr),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_prot  (res_prot),
    .res_paddr (res_paddr)
);

// File: tb/zoned_tlb_lookup_test.sv
`timescale 1ns/1ps
module zoned_tlb_lookup_test;

    localparam int N  = 8;
    localparam int ZC = 8;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [31:0] wr_tag = '0, wr_data = '0;
    logic [7:0] wr_tid = '0;
    logic lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0] lk_kind = '0;
    logic lk_user = 1'b0;
    logic [7:0] cur_pid = '0;
    logic [31:0] zone_reg = '0;
    logic res_hit, res_miss, res_prot;
    logic [IW-1:0] res_idx;
    logic [31:0] res_paddr;
    logic [2:0] res_size;

    int total = 0;
    int bad = 0;

    // Bench copy of what it loaded into each slot (stimulus record).
    logic [31:0] m_va [N];
    logic [2:0]  m_sz [N];
    logic        m_v  [N];
    logic [7:0]  m_tid[N];
    logic [31:0] m_pa [N];
    logic        m_ex [N];
    logic        m_wr [N];
    logic [3:0]  m_zs [N];

    always #2.5 clk = ~clk;

    zoned_tlb_lookup #(.ENTRIES(N), .ZONE_COUNT(ZC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_data(wr_data), .wr_tid(wr_tid),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
        .lk_user(lk_user), .cur_pid(cur_pid), .zone_reg(zone_reg),
        .res_hit(res_hit), .res_miss(res_miss), .res_prot(res_prot),
        .res_idx(res_idx), .res_paddr(res_paddr), .res_size(res_size)
    );

    task automatic put(input int i, input logic [31:0] va, input logic [2:0] sz,
                       input logic v, input logic [7:0] tid, input logic [31:0] pa,
                       input logic ex, input logic wr, input logic [3:0] zs);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = IW'(i);
        wr_tag  = {va[31:10], sz, v, 6'b0};
        wr_data = {pa[31:10], ex, wr, zs, 4'b0};
        wr_tid  = tid;
        m_va[i] = va; m_sz[i] = sz; m_v[i] = v; m_tid[i] = tid;
        m_pa[i] = pa; m_ex[i] = ex; m_wr[i] = wr; m_zs[i] = zs;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) put(i, 32'h0, 3'd0, 1'b0, 8'd0, 32'h0, 1'b0, 1'b0, 4'd0);
    endtask

    // Model from the requirements: oc 0 miss, 1 hit, 2 fault.
    task automatic model(input logic [31:0] va, input logic [1:0] kind, input logic user,
                         output int oc, output int idx, output logic [31:0] pa,
                         output logic [2:0] sz);
        logic [31:0] mask;
        int code;
        logic w, x;
        oc = 0; idx = 0; pa = 0; sz = 0;
        for (int i = 0; i < N; i++) begin
            if (!m_v[i]) continue;
            mask = 32'hFFFF_FFFF << (10 + 2 * int'(m_sz[i]));
            if (((va ^ m_va[i]) & mask) != 0) continue;
            if (m_tid[i] != 0 && m_tid[i] != cur_pid) continue;
            if (int'(m_zs[i]) > ZC) code = 1;
            else code = int'((zone_reg >> (30 - 2 * int'(m_zs[i]))) & 32'd3);
            if (code == 0 && user) continue;
            w = m_wr[i] || code == 3 || (code == 2 && !user);
            x = m_ex[i] || code == 3 || (code == 2 && !user);
            idx = i; sz = m_sz[i];
            if ((kind == 2'd1 && !w) || (kind == 2'd2 && !x)) begin
                oc = 2;
            end else begin
                oc = 1;
                pa = (m_pa[i] & mask) | (va & ~mask);
            end
            return;
        end
    endtask

    task automatic look(input string req, input logic [31:0] va,
                        input logic [1:0] kind, input logic user);
        int oc, idx;
        logic [31:0] pa;
        logic [2:0] sz;
        logic ok;
        model(va, kind, user, oc, idx, pa, sz);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind; lk_user = user;
        @(negedge clk);
        lk_valid = 1'b0;
        ok = (res_hit == (oc == 1)) && (res_miss == (oc == 0)) && (res_prot == (oc == 2));
        if (oc != 0) ok = ok && res_idx == IW'(idx) && res_size == sz;
        if (oc == 1) ok = ok && res_paddr == pa;
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s va=%h kind=%0d user=%0d: got h/m/p=%0d%0d%0d idx=%0d pa=%h sz=%0d, expected outcome=%0d idx=%0d pa=%h sz=%0d",
                     req, va, kind, user, res_hit, res_miss, res_prot, res_idx, res_paddr,
                     res_size, oc, idx, pa, sz);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_va[i] = 0; m_sz[i] = 0; m_tid[i] = 0;
            m_pa[i] = 0; m_ex[i] = 0; m_wr[i] = 0; m_zs[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        total++;
        if ({res_hit, res_miss, res_prot, res_idx, res_paddr, res_size} != '0) begin
            bad++;
            $display("FAIL R10 reset: got %b%b%b %h, expected all zero", res_hit, res_miss, res_prot, res_paddr);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset, no request
        total++;
        if (res_hit || res_miss || res_prot) begin
            bad++;
            $display("FAIL R10 idle: got %b%b%b, expected 000", res_hit, res_miss, res_prot);
        end

        // R8: empty table misses
        look("R8", 32'h1234_5678, 2'd0, 1'b0);
        look("R8", 32'hFFFF_FC00, 2'd2, 1'b1);

        // R1: every size code, offsets in and around the page
        zone_reg = 32'hFFFF_FFFF;
        for (int c = 0; c < 8; c++) begin
            int pg = 1024 << (2 * c);
            put(0, 32'h4000_0000, 3'(c), 1'b1, 8'd0, 32'h8100_0000, 1'b0, 1'b0, 4'd2);
            look("R1", 32'h4000_0000, 2'd0, 1'b1);
            look("R1", 32'h4000_0000 + 32'(pg - 1), 2'd0, 1'b1);
            look("R1", 32'h4000_0000 + 32'(pg / 2 + 3), 2'd1, 1'b0);
            look("R1", 32'h4000_0000 + 32'(pg), 2'd0, 1'b0);
            look("R1", 32'h3FFF_FFFF, 2'd0, 1'b0);
        end

        // R2: invalid slot is skipped
        clear_all();
        put(1, 32'h2000_0000, 3'd1, 1'b0, 8'd0, 32'h0000_1000, 1'b1, 1'b1, 4'd0);
        look("R2", 32'h2000_0010, 2'd0, 1'b0);

        // R3: owner tag against every process ID in a range
        put(1, 32'h2000_0000, 3'd1, 1'b1, 8'd5, 32'h0000_1000, 1'b1, 1'b1, 4'd0);
        put(2, 32'h3000_0000, 3'd1, 1'b1, 8'd0, 32'h0000_2000, 1'b1, 1'b1, 4'd0);
        for (int p = 0; p < 8; p++) begin
            cur_pid = 8'(p);
            look("R3", 32'h2000_0044, 2'd0, 1'b0);
            look("R3", 32'h3000_0088, 2'd0, 1'b1);
        end
        cur_pid = 8'd0;

        // R4 R5 R7: zone code x mode x kind x rights
        clear_all();
        for (int code = 0; code < 4; code++) begin
            zone_reg = (32'h5555_5555 & ~(32'h3 << 24)) | (32'(code) << 24);
            for (int r = 0; r < 4; r++) begin
                put(0, 32'h1000_0000, 3'd1, 1'b1, 8'd0, 32'h0ABC_D000, r[1], r[0], 4'd3);
                for (int u = 0; u < 2; u++)
                    for (int k = 0; k < 3; k++)
                        look(code == 0 ? "R4" : "R5", 32'h1000_0ABC, 2'(k), u[0]);
            end
        end

        // R6: zone selects above ZONE_COUNT act as code 1 even with all codes 0
        zone_reg = 32'h0;
        for (int z = ZC; z < 16; z++) begin
            put(0, 32'h1000_0000, 3'd1, 1'b1, 8'd0, 32'h0ABC_D000, 1'b0, 1'b1, 4'(z));
            look("R6", 32'h1000_0123, 2'd0, 1'b1);
            look("R6", 32'h1000_0123, 2'd1, 1'b1);
            look("R6", 32'h1000_0123, 2'd2, 1'b0);
        end

        // R4: a user-blocked slot lets the search fall through to a later slot
        zone_reg = 32'h0;
        put(0, 32'h1000_0000, 3'd1, 1'b1, 8'd0, 32'h0ABC_D000, 1'b1, 1'b1, 4'd1);
        put(1, 32'h1000_0000, 3'd2, 1'b1, 8'd0, 32'h0DEF_0000, 1'b1, 1'b1, 4'd9);
        look("R4", 32'h1000_0200, 2'd0, 1'b1);
        look("R4", 32'h1000_0200, 2'd0, 1'b0);

        // R7: a fault on the first match ends the search
        zone_reg = 32'h5555_5555;
        put(0, 32'h1000_0000, 3'd1, 1'b1, 8'd0, 32'h0ABC_D000, 1'b0, 1'b0, 4'd1);
        put(1, 32'h1000_0000, 3'd1, 1'b1, 8'd0, 32'h0DEF_0000, 1'b1, 1'b1, 4'd1);
        look("R7", 32'h1000_0010, 2'd1, 1'b0);
        look("R7", 32'h1000_0010, 2'd2, 1'b1);

        // R9: lowest index wins among several matches
        clear_all();
        put(5, 32'h6000_0000, 3'd3, 1'b1, 8'd0, 32'h0500_0000, 1'b1, 1'b1, 4'd1);
        put(2, 32'h6000_0000, 3'd5, 1'b1, 8'd0, 32'h0200_0000, 1'b1, 1'b1, 4'd1);
        look("R9", 32'h6000_1234, 2'd0, 1'b0);
        look("R9", 32'h6008_0000, 2'd2, 1'b1);

        // R11: rewriting a slot changes the next lookup
        put(2, 32'h7000_0000, 3'd0, 1'b1, 8'd0, 32'h0777_0000, 1'b1, 1'b1, 4'd1);
        look("R11", 32'h6000_1234, 2'd0, 1'b0);
        look("R11", 32'h7000_03FF, 2'd1, 1'b0);

        // R10: back-to-back requests and idle afterwards
        @(negedge clk);
        total++;
        if (res_hit || res_miss || res_prot) begin
            bad++;
            $display("FAIL R10 idle after requests: got %b%b%b, expected 000", res_hit, res_miss, res_prot);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule